// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers one-cycle event pulses from peripheral sources into a latched pending register, qualifies that register with a programmable enable mask, and drives a single interrupt request towards the processor. Source bit 0 carries the vertical-blank event and source bit 2 carries the disc-drive event; the other source bits are free for further peripherals.

Software sees two registers on a small write/read port. The pending register sits at offset 0 and the enable register at offset 4. A pending flag is acknowledged by writing a zero into its bit position; ones written to the pending register leave flags untouched. Writes may be full 32-bit or 16-bit, the latter touching only the low half of the selected register. Reads are combinational on the address. The request line follows the pending and enable registers directly, so it falls in the cycle after any write that leaves no enabled flag pending.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the pending register and the enable register read as zero and irq_o is low.
- R2: A high level on src_pulse_i[k] at a clock edge sets pending bit k (bit 0 vertical blank, bit 2 disc drive); a read at offset 0 returns the pending bits in rd_data_o[10:0] with bits 31:11 zero.
- R3: A write to offset 0 replaces the pending register with its AND with the written value: a written 0 clears the flag, a written 1 keeps it as it was.
- R4: A write to offset 4 replaces the enable register with the written value; a read at offset 4 returns it in rd_data_o[10:0] with bits 31:11 zero.
- R5: irq_o is the OR over all bits of (pending AND enable); a pulse on an enabled source raises irq_o in the cycle after the clock edge that samples it.
- R6: irq_o is low in the cycle after a write that leaves (pending AND enable) equal to zero, whether that write acknowledges flags or narrows the enable register.
- R7: When a source pulse and a write of 0 to the same pending bit meet at one clock edge, the bit ends up set.
- R8: With wr_half_i high a write uses only wr_data_i[15:0]; bits 31:16 of the selected register keep their value, whatever wr_data_i[31:16] holds.
- R9: A write to any offset other than 0 or 4 changes neither register, and a read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pulse_i | input | 11 | One-cycle event pulses, one per source |
| addr_i | input | 3 | Register byte offset for writes and reads |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_half_i | input | 1 | 1 = 16-bit write, 0 = 32-bit write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions take for granted that every input is a known value at each clock edge after reset and that a source may hold its pulse high for several cycles, which simply re-sets the flag each edge. The stimulus changes inputs only on the falling edge and, beyond directed sweeps over every source bit and every single-bit enable, drives a long pseudo-random mix of pulses, full and half writes and stray offsets, with the bench keeping its own register model from the requirements.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_PEND = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_ENAB = 3'd4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_ENAB = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output reg_sel_e          sel_o,
  output logic              wr_pend_o,
  output logic              wr_enab_o
);
  always_comb begin
    unique case (addr_i)
      OFS_PEND: sel_o = SEL_PEND;
      OFS_ENAB: sel_o = SEL_ENAB;
      default:  sel_o = SEL_NONE;
    endcase
  end

  assign wr_pend_o = wr_en_i && (sel_o == SEL_PEND);
  assign wr_enab_o = wr_en_i && (sel_o == SEL_ENAB);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic               wr_pend_i,
  input  logic               wr_half_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    localparam bit UPPER = (k >= HALF_W);
    logic ack;
    // written zero clears, unless a half write leaves this bit out
    assign ack = wr_pend_i && !wr_data_i[k] && !(wr_half_i && UPPER);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             pend_q[k] <= 1'b0;
      else if (src_pulse_i[k]) pend_q[k] <= 1'b1;
      else if (ack)            pend_q[k] <= 1'b0;
    end

    AST_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_pulse_i[k] |=> pend_o[k]); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_pend_i && !wr_half_i && !wr_data_i[k] && !src_pulse_i[k]) |=> !pend_o[k]); // R3
    AST_ONES_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[k] && !(wr_pend_i && !wr_data_i[k])) |=> pend_o[k]); // R3
    AST_PULSE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_pulse_i[k] && wr_pend_i && !wr_data_i[k]) |=> pend_o[k]); // R7
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_enab_reg.sv
module irq_enab_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_enab_i,
  input  logic               wr_half_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_SRC-1:0] enab_o
);
  logic [NUM_SRC-1:0] enab_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    localparam bit UPPER = (k >= HALF_W);
    logic load;
    assign load = wr_enab_i && !(wr_half_i && UPPER);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   enab_q[k] <= 1'b0;
      else if (load) enab_q[k] <= wr_data_i[k];
    end
  end

  AST_ENAB_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_enab_i && !wr_half_i) |=> enab_o == $past(wr_data_i[NUM_SRC-1:0])); // R4
  AST_ENAB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_enab_i |=> $stable(enab_o)); // R9

  assign enab_o = enab_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               wr_half_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  reg_sel_e           sel;
  logic               wr_pend, wr_enab;
  logic [NUM_SRC-1:0] pend, enab;

  irq_reg_decode u_dec (
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .sel_o     (sel),
    .wr_pend_o (wr_pend),
    .wr_enab_o (wr_enab)
  );

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_pulse_i (src_pulse_i),
    .wr_pend_i   (wr_pend),
    .wr_half_i   (wr_half_i),
    .wr_data_i   (wr_data_i),
    .pend_o      (pend)
  );

  irq_enab_reg #(.NUM_SRC(NUM_SRC)) u_enab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_enab_i (wr_enab),
    .wr_half_i (wr_half_i),
    .wr_data_i (wr_data_i),
    .enab_o    (enab)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND: rd_data_o = {{PAD_W{1'b0}}, pend};
      SEL_ENAB: rd_data_o = {{PAD_W{1'b0}}, enab};
      default:  rd_data_o = '0;
    endcase
  end

  assign irq_o = |(pend & enab);

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|src_pulse_i) || $past(wr_enab))); // R5
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_pend || wr_enab)); // R6
  AST_PEND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pend && src_pulse_i == '0) |=> $stable(pend)); // R9
endmodule

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  localparam int N = 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_pulse_i = '0;
  logic [2:0]    addr_i = '0;
  logic          wr_en_i = 1'b0;
  logic          wr_half_i = 1'b0;
  logic [31:0]   wr_data_i = '0;
  logic [31:0]   rd_data_o;
  logic          irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N-1:0] m_pend = '0, m_enab = '0;
  logic [31:0]  rng = 32'h1234_5678;

  always #5 clk_i = ~clk_i;

  irq_ctrl #(.NUM_SRC(N)) dut_i (.*);

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // read back both registers and the request line at the ports
  task automatic check_all(string tag);
    addr_i = 3'd0; #1;
    cmp({tag, " pend"}, rd_data_o, {21'd0, m_pend});
    addr_i = 3'd4; #1;
    cmp({tag, " enab"}, rd_data_o, {21'd0, m_enab});
    cmp({tag, " irq"}, {31'd0, irq_o}, {31'd0, |(m_pend & m_enab)});
  endtask

  // one cycle: drive at negedge, update model at posedge from the spec
  task automatic op(logic [N-1:0] p, logic we, logic hw, logic [2:0] a, logic [31:0] d);
    logic [31:0] eff_p, eff_e;
    @(negedge clk_i);
    src_pulse_i = p; wr_en_i = we; wr_half_i = hw; addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    eff_p = hw ? {16'hFFFF, d[15:0]} : d;
    eff_e = hw ? {16'h0000, d[15:0]} : d;
    if (we && a == 3'd0) m_pend = m_pend & eff_p[N-1:0];
    if (we && a == 3'd4) m_enab = eff_e[N-1:0];
    m_pend = m_pend | p;
    #2;
    src_pulse_i = '0; wr_en_i = 1'b0; wr_half_i = 1'b0; wr_data_i = '0;
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #23; check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i); check_all("R1 after release");

    for (int b = 0; b < N; b++) begin
      op(N'(1) << b, 1'b0, 1'b0, 3'd0, 32'd0); check_all("R2 pulse");
      op('0, 1'b1, 1'b0, 3'd0, 32'd0);          check_all("R3 ack all");
    end

    for (int b = 0; b < N; b++) begin
      op('0, 1'b1, 1'b0, 3'd4, 32'd1 << b);           check_all("R4 enab");
      op(N'(1) << ((b + 1) % N), 1'b0, 1'b0, 3'd0, 0); check_all("R5 unmasked no irq");
      op(N'(1) << b, 1'b0, 1'b0, 3'd0, 0);             check_all("R5 masked irq");
      op('0, 1'b1, 1'b0, 3'd0, ~(32'd1 << b));         check_all("R6 ack drops irq");
      op('0, 1'b1, 1'b0, 3'd0, 32'd0);                 check_all("R3 clear rest");
    end

    op('0, 1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF); check_all("R4 full enab upper zero");
    op(11'h7FF, 1'b0, 1'b0, 3'd0, 0);        check_all("R2 all set");
    op('0, 1'b1, 1'b0, 3'd0, 32'h0000_0555); check_all("R3 ones keep");
    op('0, 1'b1, 1'b0, 3'd4, 32'd0);         check_all("R6 mask drops irq");
    op(11'h004, 1'b1, 1'b0, 3'd0, 32'd0);    check_all("R7 pulse wins");
    op('0, 1'b1, 1'b1, 3'd0, 32'h0000_FFFF); check_all("R8 half keep");
    op('0, 1'b1, 1'b1, 3'd4, 32'hABCD_0123); check_all("R8 half enab");
    op('0, 1'b1, 1'b1, 3'd0, 32'hFFFF_0000); check_all("R8 half ack");
    op(11'h0F0, 1'b1, 1'b0, 3'd2, 32'd0);    check_all("R9 stray write");
    op('0, 1'b1, 1'b0, 3'd6, 32'd0);         check_all("R9 stray write");
    addr_i = 3'd2; #1; cmp("R9 stray read", rd_data_o, 32'd0);
    addr_i = 3'd7; #1; cmp("R9 stray read", rd_data_o, 32'd0);

    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] p;
      rng = nxt(rng);
      p = (rng[3:0] < 4'd5) ? rng[26:16] : '0;
      op(p, rng[4], rng[5], (rng[6] ? 3'd4 : 3'd0) ^ {1'b0, rng[7], 1'b0} & {3{rng[8] & rng[9]}},
         nxt(rng ^ 32'h9E37_79B9));
      check_all("R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule